// File: doc/BRIEF.md
# Flood Broadcast Spanning-Tree Node

This block is a single node in a two-dimensional mesh. Each node reaches only its four nearest neighbours, and there is no long-distance wiring. The nodes take part in a flooding broadcast. The broadcast starts at one anchor node and spreads outward. While it spreads, every node records the link on which the broadcast first reached it and treats that link as its parent. Taken across the whole mesh, these parent links form a spanning tree rooted at the anchor.

A neighbour that failed self-test is fail-stop: it never forwards and never answers. The region behind such a neighbour therefore drops out of the tree on its own, and no node stores a map of defects. A per-link enable mask from self-test silences a link in both directions.

After a node forwards the broadcast, it sends a child-claim token back to its parent. Each node collects the claims it receives into a child mask. Loading a new broadcast identifier clears the node so that a fresh tree can be built. Each link word carries a 2-bit kind in its top bits (01 = flood, 10 = claim, 00 = none) above an identifier field of `ID_W` bits.

Top module: `flood_tree_node`

## Requirements
- R1: After reset, no link output is valid, every output word is zero, and the seen flag, the parent-present flag and the child mask are all zero.
- R2: Suppose a flood word whose identifier equals the current broadcast identifier arrives on an enabled link while the seen flag is clear. Then on the next cycle the node sends a flood word carrying that identifier on every enabled link except the arrival link. It also sets the seen flag, sets the parent-present flag and latches the arrival link as the parent port.
- R3: While the seen flag is set, further flood words cause no output at all and leave the parent port unchanged. The node forwards each broadcast only once.
- R4: If flood words arrive on several enabled links in the same cycle, the lowest-numbered link becomes the parent port.
- R5: In the same cycle as the forward of R2, the node sends a claim word (kind 10) carrying the current identifier on the parent port.
- R6: While the seen flag is set, a claim word with the current identifier on an enabled link that is not the parent sets that link's bit in the child mask. Claim words with any other identifier are ignored.
- R7: When the anchor-select input is high and the seen flag is clear, the node sets the seen flag without a parent and, on the next cycle, sends a flood word on every enabled link. The anchor start takes priority over flood words arriving in that same cycle.
- R8: When the broadcast-identifier input differs from the stored identifier, the next clock edge stores the new identifier and clears the seen flag, the parent-present flag and the child mask. Link inputs in that cycle are ignored.
- R9: A link whose enable bit is low is never driven, and flood or claim words arriving on it are ignored.
- R10: A flood word whose identifier differs from the current broadcast identifier is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | NL | Per-link self-test enable mask |
| anchor_sel | input | 1 | Makes this node the root that starts the broadcast |
| bcast_id | input | ID_W | Current broadcast identifier |
| in_vld | input | NL | Per-link incoming word valid |
| in_msg | input | NL x MSG_W | Per-link incoming word {kind, id} |
| out_vld | output | NL | Per-link outgoing word valid |
| out_msg | output | NL x MSG_W | Per-link outgoing word {kind, id}, zero when not valid |
| seen | output | 1 | The current broadcast has been taken in |
| has_parent | output | 1 | A parent port is latched |
| parent_port | output | PW | Index of the parent link |
| child_mask | output | NL | Links that have claimed this node as parent |

## Verification
The hardest situations to reach from the ports are two races. In the first, copies of the flood reach several links in the same clock cycle. In the second, the anchor start coincides with an incoming flood. The bench creates both by raising the valid inputs of two links, or a valid input together with anchor-select, at the same falling edge, so that one rising edge samples them all. It then reads the chosen parent and the shape of the forwarded burst on the very next cycle. A duplicate copy is sent only after the node has already taken the broadcast in, and an unrelated claim is sent only after a real child has claimed. This shows that stale traffic leaves the latched state unchanged.

// File: rtl/ftn_pkg.sv
package ftn_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        MSG_NONE  = 2'b00,
        MSG_FLOOD = 2'b01,
        MSG_CLAIM = 2'b10
    } msg_kind_e;

endpackage

// File: rtl/ftn_link_rx.sv
module ftn_link_rx
    import ftn_pkg::*;
#(
    parameter int ID_W = 8,
    localparam int MSG_W = ID_W + KIND_W
) (
    input  logic             vld,
    input  logic [MSG_W-1:0] msg,
    input  logic             en,
    input  logic [ID_W-1:0]  cur_id,
    output logic             flood_hit,
    output logic             claim_hit
);
    logic [KIND_W-1:0] kind;
    logic              id_match;
    logic              live;

    always_comb begin
        kind      = msg[MSG_W-1:ID_W];
        id_match  = (msg[ID_W-1:0] == cur_id);
        live      = vld && en && id_match;
        flood_hit = live && (kind == MSG_FLOOD);
        claim_hit = live && (kind == MSG_CLAIM);
    end
endmodule

// File: rtl/ftn_low_pick.sv
module ftn_low_pick #(
    parameter int NL = 4,
    localparam int PW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [NL-1:0] req,
    output logic          any,
    output logic [PW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (req[i]) idx = PW'(i);
        end
    end
endmodule

// File: rtl/ftn_link_tx.sv
module ftn_link_tx
    import ftn_pkg::*;
#(
    parameter int ID_W = 8,
    localparam int MSG_W = ID_W + KIND_W
) (
    input  logic             send_flood,
    input  logic             send_claim,
    input  logic [ID_W-1:0]  cur_id,
    output logic             vld,
    output logic [MSG_W-1:0] msg
);
    always_comb begin
        vld = send_flood || send_claim;
        if (send_claim)      msg = {MSG_CLAIM, cur_id};
        else if (send_flood) msg = {MSG_FLOOD, cur_id};
        else                 msg = '0;
    end
endmodule

// File: rtl/flood_tree_node.sv
module flood_tree_node
    import ftn_pkg::*;
#(
    parameter int NL   = 4,
    parameter int ID_W = 8,
    localparam int MSG_W = ID_W + KIND_W,
    localparam int PW    = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NL-1:0]              link_en,
    input  logic                       anchor_sel,
    input  logic [ID_W-1:0]            bcast_id,
    input  logic [NL-1:0]              in_vld,
    input  logic [NL-1:0][MSG_W-1:0]   in_msg,
    output logic [NL-1:0]              out_vld,
    output logic [NL-1:0][MSG_W-1:0]   out_msg,
    output logic                       seen,
    output logic                       has_parent,
    output logic [PW-1:0]              parent_port,
    output logic [NL-1:0]              child_mask
);
    typedef struct packed {
        logic            seen;
        logic            has_par;
        logic [PW-1:0]   par;
        logic [NL-1:0]   kids;
        logic [ID_W-1:0] id;
        logic [NL-1:0]   fl;
        logic [NL-1:0]   cl;
    } node_st_t;

    node_st_t st_d, st_q;

    logic [NL-1:0] flood_hit, claim_hit;
    logic          flood_any;
    logic [PW-1:0] pick_idx;
    logic [NL-1:0] pick_oh, par_oh;
    logic          new_id;

    // receive side: one decoder per link
    for (genvar g = 0; g < NL; g++) begin : g_rx
        ftn_link_rx #(.ID_W(ID_W)) i_rx (
            .vld       (in_vld[g]),
            .msg       (in_msg[g]),
            .en        (link_en[g]),
            .cur_id    (st_q.id),
            .flood_hit (flood_hit[g]),
            .claim_hit (claim_hit[g])
        );
    end

    ftn_low_pick #(.NL(NL)) i_pick (
        .req (flood_hit),
        .any (flood_any),
        .idx (pick_idx)
    );

    always_comb begin
        new_id  = (bcast_id != st_q.id);
        pick_oh = NL'(1) << pick_idx;
        par_oh  = st_q.has_par ? (NL'(1) << st_q.par) : '0;

        st_d    = st_q;
        st_d.fl = '0;
        st_d.cl = '0;

        if (new_id) begin
            st_d.id      = bcast_id;
            st_d.seen    = 1'b0;
            st_d.has_par = 1'b0;
            st_d.par     = '0;
            st_d.kids    = '0;
        end else if (!st_q.seen && anchor_sel) begin
            st_d.seen    = 1'b1;
            st_d.has_par = 1'b0;
            st_d.fl      = link_en;
        end else if (!st_q.seen && flood_any) begin
            st_d.seen    = 1'b1;
            st_d.has_par = 1'b1;
            st_d.par     = pick_idx;
            st_d.fl      = link_en & ~pick_oh;
            st_d.cl      = link_en & pick_oh;
        end else if (st_q.seen) begin
            st_d.kids    = st_q.kids | (claim_hit & ~par_oh);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // transmit side: one encoder per link
    for (genvar g = 0; g < NL; g++) begin : g_tx
        ftn_link_tx #(.ID_W(ID_W)) i_tx (
            .send_flood (st_q.fl[g]),
            .send_claim (st_q.cl[g]),
            .cur_id     (st_q.id),
            .vld        (out_vld[g]),
            .msg        (out_msg[g])
        );
    end

    assign seen        = st_q.seen;
    assign has_parent  = st_q.has_par;
    assign parent_port = st_q.par;
    assign child_mask  = st_q.kids;

    // flood words seen at the output ports
    logic [NL-1:0] out_flood;
    for (genvar g = 0; g < NL; g++) begin : g_of
        assign out_flood[g] = out_vld[g] && (out_msg[g][MSG_W-1:ID_W] == MSG_FLOOD);
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld & ~$past(link_en)) == '0); // R9

    AST_FORWARD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_flood) |-> $rose(seen)); // R3

    AST_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_flood) && has_parent) |-> !out_flood[parent_port]); // R2

    AST_ANCHOR_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seen) && $past(anchor_sel)) |-> !has_parent); // R7

    AST_NEW_ID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_id != st_q.id) |=> (!seen && !has_parent && child_mask == '0)); // R8

    AST_CHILD_NOT_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        has_parent |-> !child_mask[parent_port]); // R6
endmodule

// File: tb/test_flood_tree_node.sv
module test_flood_tree_node;
    localparam int NL    = 4;
    localparam int ID_W  = 8;
    localparam int MSG_W = ID_W + 2;
    localparam int PW    = 2;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NL-1:0]            link_en;
    logic                     anchor_sel;
    logic [ID_W-1:0]          bcast_id;
    logic [NL-1:0]            in_vld;
    logic [NL-1:0][MSG_W-1:0] in_msg;
    logic [NL-1:0]            out_vld;
    logic [NL-1:0][MSG_W-1:0] out_msg;
    logic                     seen, has_parent;
    logic [PW-1:0]            parent_port;
    logic [NL-1:0]            child_mask;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    flood_tree_node #(.NL(NL), .ID_W(ID_W)) i_flood_tree_node (
        .clk, .rst_n, .link_en, .anchor_sel, .bcast_id, .in_vld, .in_msg,
        .out_vld, .out_msg, .seen, .has_parent, .parent_port, .child_mask
    );

    function automatic logic [MSG_W-1:0] fw(logic [ID_W-1:0] id);
        return {2'b01, id};
    endfunction
    function automatic logic [MSG_W-1:0] cw(logic [ID_W-1:0] id);
        return {2'b10, id};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // drive inputs for one sampling edge, then drop them
    task automatic pulse();
        tick();
        in_vld = '0;
        in_msg = '0;
        anchor_sel = 1'b0;
    endtask

    task automatic set_id(logic [ID_W-1:0] v);
        bcast_id = v;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 out_vld", out_vld, 0);
        chk("R1 out_msg", out_msg, 0);
        chk("R1 seen", seen, 0);
        chk("R1 has_parent", has_parent, 0);
        chk("R1 child_mask", child_mask, 0);
    endtask

    task automatic t_basic();
        link_en = 4'b1111;
        set_id(8'h05);
        in_vld[2] = 1'b1; in_msg[2] = fw(8'h05);
        pulse();
        chk("R2 out_vld", out_vld, 4'b1111);
        chk("R2 flood words", {out_msg[3], out_msg[1], out_msg[0]},
            {fw(8'h05), fw(8'h05), fw(8'h05)});
        chk("R5 claim on parent", out_msg[2], cw(8'h05));
        chk("R2 parent", {has_parent, parent_port}, {1'b1, 2'd2});
        chk("R2 seen", seen, 1);
        tick();
        chk("R2 single burst", out_vld, 0);
        in_vld[0] = 1'b1; in_msg[0] = fw(8'h05);
        pulse();
        chk("R3 duplicate quiet", out_vld, 0);
        chk("R3 parent kept", parent_port, 2);
        in_vld[1] = 1'b1; in_msg[1] = cw(8'h05);
        pulse();
        chk("R6 child set", child_mask, 4'b0010);
        in_vld[3] = 1'b1; in_msg[3] = cw(8'h09);
        pulse();
        chk("R6 foreign claim ignored", child_mask, 4'b0010);
        set_id(8'h06);
        chk("R8 cleared", {seen, has_parent, child_mask}, 0);
    endtask

    task automatic t_tie();
        link_en = 4'b1111;
        set_id(8'h16);
        in_vld = 4'b1010; in_msg[1] = fw(8'h16); in_msg[3] = fw(8'h16);
        pulse();
        chk("R4 lowest wins", parent_port, 1);
        chk("R4 floods", {out_msg[3], out_msg[2], out_msg[0]},
            {fw(8'h16), fw(8'h16), fw(8'h16)});
        chk("R5 claim", out_msg[1], cw(8'h16));
    endtask

    task automatic t_disabled();
        link_en = 4'b1101;
        set_id(8'h27);
        in_vld[1] = 1'b1; in_msg[1] = fw(8'h27);
        pulse();
        chk("R9 disabled input ignored", {seen, out_vld}, 0);
        in_vld[0] = 1'b1; in_msg[0] = fw(8'h27);
        pulse();
        chk("R9 disabled not driven", out_vld, 4'b1101);
        chk("R9 port1 word zero", out_msg[1], 0);
        in_vld[1] = 1'b1; in_msg[1] = cw(8'h27);
        pulse();
        chk("R9 disabled claim ignored", child_mask, 0);
    endtask

    task automatic t_wrong_id();
        link_en = 4'b1111;
        set_id(8'h38);
        in_vld[3] = 1'b1; in_msg[3] = fw(8'h03);
        pulse();
        chk("R10 wrong id ignored", {seen, out_vld}, 0);
    endtask

    task automatic t_anchor();
        link_en = 4'b0111;
        set_id(8'h49);
        anchor_sel = 1'b1;
        in_vld[2] = 1'b1; in_msg[2] = fw(8'h49);
        pulse();
        chk("R7 floods all enabled", out_vld, 4'b0111);
        chk("R7 flood words", {out_msg[2], out_msg[1], out_msg[0]},
            {fw(8'h49), fw(8'h49), fw(8'h49)});
        chk("R7 no parent", {seen, has_parent}, 2'b10);
        anchor_sel = 1'b1;
        pulse();
        chk("R3 anchor forwards once", out_vld, 0);
        in_vld[2] = 1'b1; in_msg[2] = cw(8'h49);
        pulse();
        chk("R6 anchor child", child_mask, 4'b0100);
        set_id(8'h4a);
        chk("R8 anchor cleared", {seen, child_mask}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        link_en = '0;
        anchor_sel = 1'b0;
        bcast_id = '0;
        in_vld = '0;
        in_msg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_tie();
        t_disabled();
        t_wrong_id();
        t_anchor();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule